// File: doc/BRIEF.md
# Saturating Fixed-Point ALU with Sticky Overflow Flags

This block is the integer arithmetic unit of a signal-processing datapath. Each clock it can add, subtract or compare two 32-bit two's-complement operands. When a saturation enable is high, a result that does not fit is clamped to the largest or smallest representable value instead of wrapping around. Every operation updates a five-bit status word that holds zero, negative, overflow, carry and an invalid bit. The invalid bit is reserved for floating-point work and always reads 0.

Next to the status word, a two-bit sticky word records overflow events. One bit records overflow in the positive direction and the other records overflow in the negative direction. Once a sticky bit is set it stays set through later operations until software pulses the clear strobe. Software can therefore run a whole block of samples and then ask once whether anything overflowed. All outputs are registered and change on the clock edge after the operation is presented.

Top module: `sat_alu`

## Requirements
- R1: After reset is asserted (rst_n low), result, status and sticky all read 0.
- R2: The opcode encoding is 0 = no operation, 1 = add (a+b), 2 = subtract (a-b), 3 = compare. With sat_en low, add and subtract write the 32-bit two's-complement result, wrapped modulo 2^32, to result on the next clock.
- R3: Status bit layout is [0] zero, [1] negative, [2] overflow, [3] carry, [4] invalid. Zero and negative describe the value after any saturation. Carry is the unsigned carry-out of a+b for add. For subtract and compare it is the carry-out of a + ~b + 1, so it is 1 exactly when a >= b unsigned. Invalid is always 0.
- R4: The overflow status bit is 1 when the true signed result lies outside the 32-bit range, whether sat_en is high or low.
- R5: With sat_en high, an overflowing add or subtract writes 0x7FFFFFFF when the true result is too large and 0x80000000 when it is too small.
- R6: Compare updates status exactly as a subtract with the same operands and sat_en would, and leaves result unchanged.
- R7: The no-operation opcode leaves result and status unchanged.
- R8: Sticky bit [0] sets on a positive-direction overflow and bit [1] sets on a negative-direction overflow, from any add, subtract or compare. A set sticky bit stays set on later operations while sticky_clr is low.
- R9: sticky_clr high clears both sticky bits on the next clock. An overflow in the same cycle still sets its bit, so the new event is kept and the old ones are dropped.
- R10: Adding -1 and 1 gives result 0 and status zero=1, negative=0, overflow=0, carry=1, invalid=0, and sets no sticky bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 2 | 0 none, 1 add, 2 subtract, 3 compare |
| a_in | input | 32 | First operand, two's complement |
| b_in | input | 32 | Second operand, two's complement |
| sat_en | input | 1 | Clamp overflowing results when high |
| sticky_clr | input | 1 | Clears the sticky word |
| result | output | 32 | Registered arithmetic result |
| status | output | 5 | Registered per-operation flags |
| sticky | output | 2 | Accumulated overflow flags |

## Verification
All of this block's state is visible at its outputs, so a wrong internal value shows up one clock after the operation that produced it. A bad overflow decision can appear at the ports in three ways: as a wrong clamp value, as a wrong overflow status bit, or as a sticky bit that sets or stays clear when it should not. The sticky word is the only state that carries history. A fault that drops or clears it early shows at the first operation that follows the event, and a wrong clear priority shows in the cycle after the strobe. The bench compares all three outputs against its own model after every clock. It covers the four overflow corners and the clear-with-overflow collision, and runs a long randomized mix with extreme operands.

// File: rtl/sat_alu.sv
module sat_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   opcode,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         sat_en,
  input  logic         sticky_clr,
  output logic [W-1:0] result,
  output logic [4:0]   status,
  output logic [1:0]   sticky
);

  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [1:0]   OP_NONE = 2'd0;
  localparam logic [1:0]   OP_CMP  = 2'd3;

  logic         active, is_sub, writes;
  logic [W-1:0] b_eff, raw, fin;
  logic [W:0]   sum_x;
  logic         carry, ovf, pos_ovf, neg_ovf;

  assign active = (opcode != OP_NONE);
  assign is_sub = opcode[1];
  assign writes = active && (opcode != OP_CMP);

  assign b_eff = is_sub ? ~b_in : b_in;
  assign sum_x = {1'b0, a_in} + {1'b0, b_eff} + (W+1)'(is_sub);
  assign raw   = sum_x[W-1:0];
  assign carry = sum_x[W];

  assign ovf     = (a_in[W-1] == b_eff[W-1]) && (raw[W-1] != a_in[W-1]);
  assign pos_ovf = ovf && !a_in[W-1];
  assign neg_ovf = ovf &&  a_in[W-1];

  assign fin = (sat_en && ovf) ? (a_in[W-1] ? MIN_NEG : MAX_POS) : raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      status <= '0;
      sticky <= '0;
    end else begin
      if (active)
        status <= {1'b0, carry, ovf, fin[W-1], (fin == '0)};
      if (writes)
        result <= fin;
      sticky <= (sticky_clr ? 2'b00 : sticky) |
                (active ? {neg_ovf, pos_ovf} : 2'b00);
    end
  end

  // R3
  invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[4] == 1'b0);

  // R3
  zero_neg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[0] && status[1]));

  // R3
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    writes |=> (status[0] == (result == '0)));

  // R5
  sat_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (writes && sat_en && pos_ovf) |=> (result == MAX_POS));

  // R5
  sat_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (writes && sat_en && neg_ovf) |=> (result == MIN_NEG));

  // R6
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OP_CMP) |=> $stable(result));

  // R7
  nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OP_NONE) |=> ($stable(result) && $stable(status)));

  // R8
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sticky_clr |=> ((sticky & $past(sticky)) == $past(sticky)));

  // R9
  sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_clr && !active) |=> (sticky == 2'b00));

endmodule

// File: tb/test_sat_alu.sv
module test_sat_alu;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  opcode = 2'd0;
  logic [31:0] a_in = '0, b_in = '0;
  logic        sat_en = 1'b0, sticky_clr = 1'b0;
  logic [31:0] result;
  logic [4:0]  status;
  logic [1:0]  sticky;

  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  logic [31:0] m_res;
  logic [4:0]  m_st;
  logic [1:0]  m_sk;

  always #(CLK_NS/2) clk = ~clk;

  sat_alu i_sat_alu (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .a_in(a_in), .b_in(b_in),
    .sat_en(sat_en), .sticky_clr(sticky_clr),
    .result(result), .status(status), .sticky(sticky)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    check(tag, "result", result, m_res);
    check(tag, "status", {27'd0, status}, {27'd0, m_st});
    check(tag, "sticky", {30'd0, sticky}, {30'd0, m_sk});
  endtask

  task automatic model(logic [1:0] op, logic [31:0] a, logic [31:0] b, bit sat, bit clr);
    longint sa, sb, t;
    longint unsigned ua, ub;
    bit v, c, up;
    logic [31:0] f;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = longint'({32'd0, a});
    ub = longint'({32'd0, b});
    if (clr) m_sk = 2'b00;
    if (op == 2'd0) return;
    if (op == 2'd1) begin
      t = sa + sb;
      c = ((ua + ub) >= 64'h1_0000_0000);
    end else begin
      t = sa - sb;
      c = (ua >= ub);
    end
    v  = (t > 64'sd2147483647) || (t < -64'sd2147483648);
    up = (t > 0);
    if (v && sat) f = up ? 32'h7FFF_FFFF : 32'h8000_0000;
    else          f = t[31:0];
    m_st = {1'b0, c, v, f[31], (f == 32'd0)};
    if (v) m_sk = m_sk | (up ? 2'b01 : 2'b10);
    if (op != 2'd3) m_res = f;
  endtask

  task automatic step(logic [1:0] op, logic [31:0] a, logic [31:0] b, bit sat, bit clr, string tag);
    @(negedge clk);
    opcode = op; a_in = a; b_in = b; sat_en = sat; sticky_clr = clr;
    @(posedge clk);
    model(op, a, b, sat, clr);
    #1;
    compare(tag);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    logic [31:0] ra, rb;
    m_res = '0; m_st = '0; m_sk = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    compare("R1");

    // R10 -1 + 1
    step(2'd1, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, "R10");
    check("R10", "status", {27'd0, status}, 32'h9);
    check("R10", "sticky", {30'd0, sticky}, 32'h0);

    // R2 wrap
    step(2'd1, 32'd100, 32'd23, 1'b0, 1'b0, "R2");
    step(2'd2, 32'd5, 32'd9, 1'b0, 1'b0, "R2");
    check("R2", "result", result, 32'hFFFF_FFFC);
    step(2'd1, 32'h7FFF_FFFF, 32'd1, 1'b0, 1'b0, "R4");
    check("R4", "result", result, 32'h8000_0000);
    check("R8", "sticky", {30'd0, sticky}, 32'h1);

    // R5 clamp both directions, add and subtract
    step(2'd1, 32'h7FFF_FFFF, 32'd1, 1'b1, 1'b0, "R5");
    check("R5", "result", result, 32'h7FFF_FFFF);
    step(2'd1, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, "R5");
    check("R5", "result", result, 32'h8000_0000);
    check("R8", "sticky", {30'd0, sticky}, 32'h3);
    step(2'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, "R5");
    step(2'd2, 32'h8000_0000, 32'd1, 1'b1, 1'b0, "R5");
    step(2'd2, 32'd0, 32'h8000_0000, 1'b1, 1'b0, "R5");

    // R8 persistence over clean ops
    step(2'd1, 32'd1, 32'd2, 1'b0, 1'b0, "R8");
    check("R8", "sticky", {30'd0, sticky}, 32'h3);

    // R9 clear alone, then clear with overflow
    step(2'd0, 32'd0, 32'd0, 1'b0, 1'b1, "R9");
    check("R9", "sticky", {30'd0, sticky}, 32'h0);
    step(2'd1, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, "R9");
    step(2'd1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b1, "R9");
    check("R9", "sticky", {30'd0, sticky}, 32'h1);

    // R6 compare and R7 no-op
    step(2'd1, 32'd40, 32'd2, 1'b0, 1'b0, "R6");
    step(2'd3, 32'd3, 32'd3, 1'b0, 1'b0, "R6");
    check("R6", "result", result, 32'd42);
    step(2'd3, 32'h8000_0000, 32'd1, 1'b1, 1'b0, "R6");
    step(2'd0, 32'd7, 32'd7, 1'b1, 1'b0, "R7");
    check("R7", "result", result, 32'd42);

    // R3 carry on subtract
    step(2'd2, 32'd9, 32'd9, 1'b0, 1'b0, "R3");
    step(2'd2, 32'd1, 32'hFFFF_FFFF, 1'b0, 1'b0, "R3");

    for (int i = 0; i < 2000; i++) begin
      ra = $urandom;
      rb = $urandom;
      case ($urandom_range(0, 3))
        0: ra = 32'h7FFF_FFFF - $urandom_range(0, 3);
        1: rb = 32'h8000_0000 + $urandom_range(0, 3);
        default: ;
      endcase
      step(2'($urandom_range(0, 3)), ra, rb, 1'($urandom), ($urandom_range(0, 15) == 0), "R8");
    end

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0; opcode = 2'd0; sticky_clr = 1'b0;
    @(posedge clk);
    m_res = '0; m_st = '0; m_sk = '0;
    #1;
    compare("R1");
    summary();
  end
endmodule